// File: doc/BRIEF.md
# Reversible Memory-Access Trace with Shadow Store

This block keeps a private shadow copy of a small word-organised data memory and a trace of the memory accesses a processor has retired. An external debug agent uses two commands, step forward and step back, to move a position counter along that trace. The shadow copy always shows the memory contents as they were at the current position. The block never needs the processor to run again to go backward or forward through history it has already seen.

Each trace entry holds the word address, the access kind (load, store or atomic), the value the word had before the access and the value it had after. A step forward at the live edge of the trace records the access that the processor presents on its retirement inputs. A step forward inside recorded history applies the stored after-value. A step back restores the stored before-value. Every command finishes in one cycle and gives either a done pulse or an error pulse.

A four-state controller tracks where the position sits. **EMPTY** means nothing is recorded. **LIVE** means the position is at the head with room left. **TRAVEL** means the position is behind the head. **FULL** means the position is at the head and the buffer has no room. The named transitions are:
- *record*: EMPTY/LIVE go to LIVE, or to FULL when the last slot fills.
- *revert*: LIVE/FULL/TRAVEL go to TRAVEL, or to EMPTY is never reached because the head is kept.
- *replay*: TRAVEL goes to TRAVEL, or returns to LIVE/FULL when the position reaches the head.
- *reject*: the state is left as it is.

Top module: `rev_trace_unit`

## Requirements
- R1: After reset, shadow word i reads INIT_BASE + i (default INIT_BASE = 32'hA500_0000). Position and head are 0, the phase is EMPTY and the overflow flag is low.
- R2: A forward step at the head with kind 2'b01 (store) records a new entry. Its before-value is the shadow word at cpu_addr and its after-value is cpu_wdata. The shadow word becomes cpu_wdata, and both position and head go up by one.
- R3: A recorded kind 2'b00 (load) stores cpu_rdata as both the before-value and the after-value, and writes cpu_rdata into the shadow word.
- R4: A recorded kind 2'b10 (atomic) stores cpu_rdata as the before-value and cpu_wdata as the after-value, and writes cpu_wdata into the shadow word.
- R5: A forward step with position below head writes that entry's after-value into the shadow, raises position by one, leaves head unchanged and ignores the retirement inputs.
- R6: A back step with position above 0 lowers position by one and writes the before-value of the entry just left into the shadow.
- R7: A back step at position 0 pulses step_err, and position, head and the shadow stay unchanged.
- R8: Stepping back and then forward again over the same entries gives the same shadow contents as the original recording pass.
- R9: A record attempt when head equals the depth (64) is rejected with step_err and sets the overflow flag. The flag stays set until reset, and stepping back or replaying still works.
- R10: Forward and back requested in the same cycle are rejected with step_err and change nothing.
- R11: A record attempt with kind 2'b11 is rejected with step_err and changes nothing.
- R12: The phase output encodes EMPTY=0, LIVE=1, TRAVEL=2, FULL=3 and always agrees with position and head.
- R13: step_done and step_err rise in the cycle after the command, last one cycle for a one-cycle command, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_fwd | input | 1 | Step-forward command |
| step_back | input | 1 | Step-back command |
| cpu_kind | input | 2 | Retired access kind: 0 load, 1 store, 2 atomic, 3 invalid |
| cpu_addr | input | 6 | Retired access word address |
| cpu_rdata | input | 32 | Data read by the retired access |
| cpu_wdata | input | 32 | Data written by the retired access |
| rd_addr | input | 6 | Shadow inspection address |
| rd_data | output | 32 | Shadow word at rd_addr (combinational) |
| position | output | 7 | Current trace position |
| head | output | 7 | Number of recorded entries |
| phase | output | 2 | Controller state |
| step_done | output | 1 | Command completed |
| step_err | output | 1 | Command rejected |
| overflow | output | 1 | Sticky: a record was refused for lack of space |

## Verification
The two functions that can meet in one cycle are the forward and backward step. Each is legal alone, and they also share the shadow write port and the trace read index. The bench raises both commands in a single cycle while position is both above 0 and equal to head. In that cycle a record, a revert or a mix of the two would all be plausible outcomes. The result is judged by an error pulse with no done pulse, unchanged position and head, and an unchanged shadow word at the address the retirement inputs name.

// File: rtl/rtrace_pkg.sv
package rtrace_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_AMO   = 2'd2,
        KIND_BAD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_LIVE   = 2'd1,
        ST_TRAVEL = 2'd2,
        ST_FULL   = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_RECORD = 3'd1,
        OP_REPLAY = 3'd2,
        OP_REVERT = 3'd3,
        OP_REJECT = 3'd4
    } op_e;

endpackage

// File: rtl/rtrace_shadow.sv
module rtrace_shadow #(
    parameter int              DATA_W    = 32,
    parameter int              WORDS     = 64,
    parameter logic [31:0]     INIT_BASE = 32'hA500_0000,
    localparam int             ADDR_W    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);

    logic [DATA_W-1:0] mem [WORDS];

    // One register per word, each with its own reset value
    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(INIT_BASE) + DATA_W'(gi);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[gi] <= RST_VAL;
            end else if (wr_en && (wr_addr == ADDR_W'(gi))) begin
                mem[gi] <= wr_data;
            end
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

    // The written word holds the written data afterwards
    AST_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R2

endmodule

// File: rtl/rtrace_buf.sv
module rtrace_buf #(
    parameter int  DATA_W = 32,
    parameter int  ADDR_W = 6,
    parameter int  DEPTH  = 64,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_kind,
    input  logic [DATA_W-1:0] wr_cur,
    input  logic [DATA_W-1:0] wr_nxt,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_kind,
    output logic [DATA_W-1:0] rd_cur,
    output logic [DATA_W-1:0] rd_nxt
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [1:0]        kind_q [DEPTH];
    logic [DATA_W-1:0] cur_q  [DEPTH];
    logic [DATA_W-1:0] nxt_q  [DEPTH];

    // Entries beyond head are never read, so storage needs no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr_q[wr_idx] <= wr_addr;
            kind_q[wr_idx] <= wr_kind;
            cur_q[wr_idx]  <= wr_cur;
            nxt_q[wr_idx]  <= wr_nxt;
        end
    end

    assign rd_addr = addr_q[rd_idx];
    assign rd_kind = kind_q[rd_idx];
    assign rd_cur  = cur_q[rd_idx];
    assign rd_nxt  = nxt_q[rd_idx];

endmodule

// File: rtl/rtrace_ctrl.sv
module rtrace_ctrl
    import rtrace_pkg::*;
#(
    parameter int  DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_fwd,
    input  logic             step_back,
    input  kind_e            cpu_kind,
    input  kind_e            ent_kind,
    output op_e              op,
    output logic [CNT_W-1:0] pos,
    output logic [CNT_W-1:0] head,
    output phase_e           phase,
    output logic             done,
    output logic             err,
    output logic             overflow
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] pos_n, head_n;
    phase_e           phase_n;
    logic             ovf_hit;

    // Command decode
    always_comb begin
        ovf_hit = 1'b0;
        op      = OP_IDLE;
        if (step_fwd && step_back) begin
            op = OP_REJECT;
        end else if (step_fwd) begin
            if (pos < head) begin
                op = OP_REPLAY;
            end else if (head == FULL_CNT) begin
                op      = OP_REJECT;
                ovf_hit = 1'b1;
            end else if (cpu_kind == KIND_BAD) begin
                op = OP_REJECT;
            end else begin
                op = OP_RECORD;
            end
        end else if (step_back) begin
            op = (pos == '0) ? OP_REJECT : OP_REVERT;
        end
    end

    // Next counters and next state
    always_comb begin
        pos_n  = pos;
        head_n = head;
        unique case (op)
            OP_RECORD: begin
                pos_n  = pos + 1'b1;
                head_n = head + 1'b1;
            end
            OP_REPLAY: pos_n = pos + 1'b1;
            OP_REVERT: pos_n = pos - 1'b1;
            OP_IDLE, OP_REJECT: ;
            default: ;
        endcase

        if (head_n == '0)              phase_n = ST_EMPTY;
        else if (pos_n < head_n)       phase_n = ST_TRAVEL;
        else if (head_n == FULL_CNT)   phase_n = ST_FULL;
        else                           phase_n = ST_LIVE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= ST_EMPTY;
            pos      <= '0;
            head     <= '0;
            overflow <= 1'b0;
        end else begin
            phase    <= phase_n;
            pos      <= pos_n;
            head     <= head_n;
            overflow <= overflow | ovf_hit;
        end
    end

    // Output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= (op == OP_RECORD) || (op == OP_REPLAY) || (op == OP_REVERT);
            err  <= (op == OP_REJECT);
        end
    end

    AST_POS_LE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= head); // R12
    AST_PHASE_TRAVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_TRAVEL) == (pos < head)); // R12
    AST_PHASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_EMPTY) == (head == '0)); // R12
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R13
    AST_BACK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_back && !step_fwd && pos == '0) |=> err); // R7
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(pos) && $stable(head))); // R10
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
    AST_RECORD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RECORD) |=> (head == CNT_W'($past(head) + 1'b1))); // R2
    AST_REPLAY_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REPLAY) |=> $stable(head)); // R5
    AST_ENTRY_KIND_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REPLAY || op == OP_REVERT) |-> (ent_kind != KIND_BAD)); // R11

endmodule

// File: rtl/rev_trace_unit.sv
module rev_trace_unit
    import rtrace_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          MEM_BYTES = 256,
    parameter int          DEPTH     = 64,
    parameter logic [31:0] INIT_BASE = 32'hA500_0000,
    localparam int         WORDS     = MEM_BYTES / (DATA_W / 8),
    localparam int         ADDR_W    = $clog2(WORDS),
    localparam int         IDX_W     = $clog2(DEPTH),
    localparam int         CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_fwd,
    input  logic              step_back,
    input  logic [1:0]        cpu_kind,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_rdata,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  position,
    output logic [CNT_W-1:0]  head,
    output logic [1:0]        phase,
    output logic              step_done,
    output logic              step_err,
    output logic              overflow
);

    op_e               op;
    phase_e            phase_q;
    kind_e             kind_in, ent_kind;
    logic [1:0]        ent_kind_raw;
    logic [ADDR_W-1:0] ent_addr;
    logic [DATA_W-1:0] ent_cur, ent_nxt;
    logic [DATA_W-1:0] sh_old;
    logic [IDX_W-1:0]  buf_rd_idx;
    logic [CNT_W-1:0]  pos_m1;

    logic              sh_we;
    logic [ADDR_W-1:0] sh_waddr;
    logic [DATA_W-1:0] sh_wdata;
    logic [DATA_W-1:0] rec_cur, rec_nxt;

    assign kind_in  = kind_e'(cpu_kind);
    assign ent_kind = kind_e'(ent_kind_raw);
    assign pos_m1   = position - 1'b1;
    assign buf_rd_idx = (op == OP_REVERT) ? pos_m1[IDX_W-1:0] : position[IDX_W-1:0];
    assign phase    = phase_q;

    rtrace_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_fwd  (step_fwd),
        .step_back (step_back),
        .cpu_kind  (kind_in),
        .ent_kind  (ent_kind),
        .op        (op),
        .pos       (position),
        .head      (head),
        .phase     (phase_q),
        .done      (step_done),
        .err       (step_err),
        .overflow  (overflow)
    );

    // Values captured into a new entry
    always_comb begin
        rec_cur = cpu_rdata;
        rec_nxt = cpu_wdata;
        unique case (kind_in)
            KIND_STORE: rec_cur = sh_old;
            KIND_LOAD:  rec_nxt = cpu_rdata;
            KIND_AMO, KIND_BAD: ;
            default: ;
        endcase
    end

    // Shadow write selection
    always_comb begin
        sh_we    = 1'b0;
        sh_waddr = cpu_addr;
        sh_wdata = rec_nxt;
        unique case (op)
            OP_RECORD: sh_we = 1'b1;
            OP_REPLAY: begin
                sh_we    = 1'b1;
                sh_waddr = ent_addr;
                sh_wdata = ent_nxt;
            end
            OP_REVERT: begin
                sh_we    = 1'b1;
                sh_waddr = ent_addr;
                sh_wdata = ent_cur;
            end
            OP_IDLE, OP_REJECT: ;
            default: ;
        endcase
    end

    rtrace_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) buf_i (
        .clk     (clk),
        .wr_en   (op == OP_RECORD),
        .wr_idx  (position[IDX_W-1:0]),
        .wr_addr (cpu_addr),
        .wr_kind (cpu_kind),
        .wr_cur  (rec_cur),
        .wr_nxt  (rec_nxt),
        .rd_idx  (buf_rd_idx),
        .rd_addr (ent_addr),
        .rd_kind (ent_kind_raw),
        .rd_cur  (ent_cur),
        .rd_nxt  (ent_nxt)
    );

    rtrace_shadow #(.DATA_W(DATA_W), .WORDS(WORDS), .INIT_BASE(INIT_BASE)) shadow_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sh_we),
        .wr_addr (sh_waddr),
        .wr_data (sh_wdata),
        .ra_addr (cpu_addr),
        .ra_data (sh_old),
        .rb_addr (rd_addr),
        .rb_data (rd_data)
    );

    // A rejected command leaves the inspected shadow word untouched
    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REJECT) |-> !sh_we); // R10

endmodule

// File: tb/rev_trace_unit_tb_top.sv
module rev_trace_unit_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'hA500_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_fwd = 1'b0, step_back = 1'b0;
    logic [1:0]  cpu_kind = 2'd0;
    logic [5:0]  cpu_addr = '0, rd_addr = '0;
    logic [31:0] cpu_rdata = '0, cpu_wdata = '0;
    logic [31:0] rd_data;
    logic [6:0]  position, head;
    logic [1:0]  phase;
    logic        step_done, step_err, overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rev_trace_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_fwd(step_fwd), .step_back(step_back),
        .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
        .cpu_wdata(cpu_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .position(position), .head(head), .phase(phase),
        .step_done(step_done), .step_err(step_err), .overflow(overflow)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Drive one command for one cycle; return with outputs settled after it
    task automatic step(input logic f, input logic b, input logic [1:0] k,
                        input logic [5:0] a, input logic [31:0] rd, input logic [31:0] wd);
        @(negedge clk);
        step_fwd = f; step_back = b; cpu_kind = k;
        cpu_addr = a; cpu_rdata = rd; cpu_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        step_fwd = 1'b0; step_back = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(6'd0, v);  chk("R1", "word0", v, BASE);
        peek(6'd5, v);  chk("R1", "word5", v, BASE + 5);
        peek(6'd63, v); chk("R1", "word63", v, BASE + 63);
        chk("R1", "position", 32'(position), 0);
        chk("R1", "head", 32'(head), 0);
        chk("R12", "phase empty", 32'(phase), 0);
        chk("R1", "overflow", 32'(overflow), 0);
    endtask

    task automatic t_back_empty();
        step(1'b0, 1'b1, 2'd1, 6'd0, '0, '0);
        chk("R7", "err", 32'(step_err), 1);
        chk("R13", "done low", 32'(step_done), 0);
        chk("R7", "position", 32'(position), 0);
        @(negedge clk);
        chk("R13", "err one cycle", 32'(step_err), 0);
    endtask

    task automatic t_record_mix();
        logic [31:0] v;
        step(1'b1, 1'b0, 2'd1, 6'd3, 32'h0, 32'h1111_1111);
        chk("R2", "store done", 32'(step_done), 1);
        peek(6'd3, v); chk("R2", "store shadow", v, 32'h1111_1111);
        chk("R2", "head", 32'(head), 1);
        chk("R12", "phase live", 32'(phase), 1);
        step(1'b1, 1'b0, 2'd0, 6'd4, 32'h2222_2222, 32'h9999_9999);
        peek(6'd4, v); chk("R3", "load shadow", v, 32'h2222_2222);
        step(1'b1, 1'b0, 2'd2, 6'd3, 32'h3333_3333, 32'h4444_4444);
        peek(6'd3, v); chk("R4", "amo shadow", v, 32'h4444_4444);
        chk("R2", "position", 32'(position), 3);
    endtask

    task automatic t_revert();
        logic [31:0] v;
        step(1'b0, 1'b1, 2'd0, 6'd0, '0, '0);
        chk("R6", "done", 32'(step_done), 1);
        peek(6'd3, v); chk("R4", "amo before-value", v, 32'h3333_3333);
        chk("R6", "position", 32'(position), 2);
        chk("R12", "phase travel", 32'(phase), 2);
        step(1'b0, 1'b1, 2'd0, 6'd0, '0, '0);
        peek(6'd4, v); chk("R3", "load before-value", v, 32'h2222_2222);
        step(1'b0, 1'b1, 2'd0, 6'd0, '0, '0);
        peek(6'd3, v); chk("R2", "store before-value", v, BASE + 3);
        chk("R6", "position zero", 32'(position), 0);
        step(1'b0, 1'b1, 2'd0, 6'd0, '0, '0);
        chk("R7", "err at zero", 32'(step_err), 1);
        peek(6'd3, v); chk("R7", "shadow kept", v, BASE + 3);
        chk("R7", "head kept", 32'(head), 3);
    endtask

    task automatic t_replay();
        logic [31:0] v;
        step(1'b1, 1'b0, 2'd1, 6'd3, 32'h0, 32'hDEAD_BEEF);
        peek(6'd3, v); chk("R5", "replay ignores cpu", v, 32'h1111_1111);
        chk("R5", "head unchanged", 32'(head), 3);
        chk("R5", "position", 32'(position), 1);
        step(1'b1, 1'b0, 2'd1, 6'd4, 32'h0, 32'hDEAD_BEEF);
        peek(6'd4, v); chk("R8", "word4 again", v, 32'h2222_2222);
        step(1'b1, 1'b0, 2'd1, 6'd3, 32'h0, 32'hDEAD_BEEF);
        peek(6'd3, v); chk("R8", "word3 again", v, 32'h4444_4444);
        chk("R12", "phase live again", 32'(phase), 1);
    endtask

    task automatic t_both();
        logic [31:0] v;
        step(1'b1, 1'b1, 2'd1, 6'd3, 32'h0, 32'h7777_7777);
        chk("R10", "err", 32'(step_err), 1);
        chk("R10", "done low", 32'(step_done), 0);
        chk("R10", "position", 32'(position), 3);
        chk("R10", "head", 32'(head), 3);
        peek(6'd3, v); chk("R10", "shadow", v, 32'h4444_4444);
    endtask

    task automatic t_bad_kind();
        logic [31:0] v;
        step(1'b1, 1'b0, 2'd3, 6'd5, 32'h0, 32'h6666_6666);
        chk("R11", "err", 32'(step_err), 1);
        chk("R11", "head", 32'(head), 3);
        peek(6'd5, v); chk("R11", "shadow", v, BASE + 5);
    endtask

    task automatic t_fill();
        logic [31:0] v;
        for (int i = 3; i < 64; i++) begin
            step(1'b1, 1'b0, 2'd1, 6'(i), 32'h0, 32'h5000_0000 + 32'(i));
        end
        chk("R12", "phase full", 32'(phase), 3);
        chk("R9", "head full", 32'(head), 64);
        chk("R9", "no overflow yet", 32'(overflow), 0);
        step(1'b1, 1'b0, 2'd1, 6'd63, 32'h0, 32'h1234_5678);
        chk("R9", "err", 32'(step_err), 1);
        chk("R9", "overflow set", 32'(overflow), 1);
        peek(6'd63, v); chk("R9", "shadow kept", v, 32'h5000_003F);
        step(1'b0, 1'b1, 2'd0, 6'd0, '0, '0);
        chk("R9", "back works", 32'(step_done), 1);
        peek(6'd63, v); chk("R6", "word63 restored", v, BASE + 63);
        chk("R9", "overflow sticky", 32'(overflow), 1);
        step(1'b1, 1'b0, 2'd0, 6'd0, '0, '0);
        peek(6'd63, v); chk("R8", "word63 replayed", v, 32'h5000_003F);
        chk("R9", "position full", 32'(position), 64);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_back_empty();
        t_record_mix();
        t_revert();
        t_replay();
        t_both();
        t_bad_kind();
        t_fill();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule